// File: doc/BRIEF.md
# Mailbox Command Requester

This block runs one complete mailbox transaction against the register window of a memory subsystem. A requester gives it a target (IP type and instance number), a command type, an opcode, seven 32-bit parameters and the number of response words it wants, from zero to three. The block then drives a single-outstanding register-bus master through a fixed sequence. It waits for the command register to go idle. It writes the non-zero parameters, posts the packed command word and polls for the response-ready flag. It then collects the status and data words and clears the ready flag with a read-modify-write.

The result comes back as a status word, up to three data words, a one-cycle done pulse and a timeout flag. Both polling phases are bounded by a parameterised poll count. A stuck command register ends the transaction before anything is written. A response that never arrives ends it with the last status word seen, and no data reads or clear write are issued. The block does not interpret commands or status codes.

Top module: `mbox_requester`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0, rsp_done is 0, rsp_timeout is 0, and rsp_status and rsp_data are zero.
- R2: After a request is accepted, the first bus accesses are reads of offset 0x43C, repeated until one returns all 32 bits zero. No write is issued before that.
- R3: Parameter i (0..6) is written to offset 0x438 − 4·i, in increasing order of i. A parameter equal to zero produces no bus access.
- R4: After the parameters, the command word is written to 0x43C, packed as IP type [31:29], instance [28:24], command type [23:16] and opcode [15:0].
- R5: Offset 0x45C is then read until bit 0 is set, and the full word read is returned on rsp_status.
- R6: The data words are read from 0x458, 0x454 and 0x450 in that order, only as many as req_nresp asks for. Word k appears at rsp_data[32k+31:32k], and unread slots stay zero.
- R7: The transaction ends with a fresh read of 0x45C, then a write of that value with only bit 0 cleared, then a one-cycle rsp_done with rsp_timeout 0.
- R8: If 0x43C reads non-zero MAX_POLLS times in a row, rsp_done pulses with rsp_timeout 1 and rsp_status zero, and no write is issued.
- R9: If 0x45C bit 0 stays clear for MAX_POLLS reads, rsp_done pulses with rsp_timeout 1. rsp_status holds the last word read, whose bits 4:1 carry the general error code and bits 7:5 the command error code. No data read and no clear write are issued.
- R10: bus_valid, bus_write, bus_addr and bus_wdata stay unchanged from the start of an access until the cycle bus_ready is seen, and only one access is open at a time.
- R11: req_ready is 0 from acceptance until after rsp_done, and req_valid during that time has no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transaction (taken when req_ready is 1) |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_ip_type | input | 3 | Target IP type |
| req_inst_id | input | 5 | Target instance number |
| req_cmd_type | input | 8 | Command type |
| req_opcode | input | 16 | Command opcode |
| req_params | input | 224 | Seven parameters, parameter i at bits 32i+31:32i |
| req_nresp | input | 2 | Number of data words to collect (0 to 3) |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte offset in the register window |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access complete |
| rsp_status | output | 32 | Returned status word |
| rsp_data | output | 96 | Returned data words, word k at bits 32k+31:32k |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Transaction ended by a poll timeout |

## Verification
A wrong state or index shows on the bus within one access. It appears as a write reaching the window out of order, as a parameter slot written with zero, or as a write where a poll read is expected. The bench logs every write and counts every read per offset, so the fault is caught at the end of the same transaction. A bad poll counter shows as a done pulse that comes too early or too late, or as a wrong timeout flag. It also changes the number of reads of 0x43C or 0x45C, which the bench compares against MAX_POLLS exactly. A corrupted read-modify-write shows as a clear write whose upper bits differ from the status word just returned.

// File: rtl/mbox_requester.sv
module mbox_requester #(
  parameter int ADDR_W    = 12,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_ip_type,
  input  logic [4:0]        req_inst_id,
  input  logic [7:0]        req_cmd_type,
  input  logic [15:0]       req_opcode,
  input  logic [223:0]      req_params,
  input  logic [1:0]        req_nresp,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ready,
  output logic [31:0]       rsp_status,
  output logic [95:0]       rsp_data,
  output logic              rsp_done,
  output logic              rsp_timeout
);

  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [ADDR_W-1:0] OFF_CMD   = ADDR_W'(12'h43C);
  localparam logic [ADDR_W-1:0] OFF_PRM0  = ADDR_W'(12'h438);
  localparam logic [ADDR_W-1:0] OFF_PRM6  = ADDR_W'(12'h420);
  localparam logic [ADDR_W-1:0] OFF_STS   = ADDR_W'(12'h45C);
  localparam logic [ADDR_W-1:0] OFF_DATA0 = ADDR_W'(12'h458);
  localparam logic [PW-1:0]     LAST_POLL = PW'(MAX_POLLS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_IDLE, S_PARAM, S_POST, S_WAIT_RSP, S_DATA, S_CLR_RD, S_CLR_WR
  } state_t;

  state_t            state;
  logic [2:0]        idx;
  logic [PW-1:0]     polls;
  logic [31:0]       cmd_word;
  logic [6:0][31:0]  prm;
  logic [1:0]        nresp;
  logic [31:0]       rmw_val;
  logic              acc;
  logic              cur_zero;

  assign req_ready = (state == S_IDLE);
  assign acc       = bus_valid & bus_ready;
  assign cur_zero  = (prm[idx] == 32'd0);

  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = OFF_CMD;
    bus_wdata = 32'd0;
    case (state)
      S_WAIT_IDLE: bus_valid = 1'b1;
      S_PARAM: begin
        bus_valid = !cur_zero;
        bus_write = 1'b1;
        bus_addr  = OFF_PRM0 - ADDR_W'({idx, 2'b00});
        bus_wdata = prm[idx];
      end
      S_POST: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_wdata = cmd_word;
      end
      S_WAIT_RSP, S_CLR_RD: begin
        bus_valid = 1'b1;
        bus_addr  = OFF_STS;
      end
      S_DATA: begin
        bus_valid = 1'b1;
        bus_addr  = OFF_DATA0 - ADDR_W'({idx, 2'b00});
      end
      S_CLR_WR: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = OFF_STS;
        bus_wdata = {rmw_val[31:1], 1'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      idx         <= '0;
      polls       <= '0;
      cmd_word    <= '0;
      prm         <= '0;
      nresp       <= '0;
      rmw_val     <= '0;
      rsp_status  <= '0;
      rsp_data    <= '0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cmd_word    <= {req_ip_type, req_inst_id, req_cmd_type, req_opcode};
          prm         <= req_params;
          nresp       <= req_nresp;
          rsp_status  <= '0;
          rsp_data    <= '0;
          rsp_timeout <= 1'b0;
          polls       <= '0;
          state       <= S_WAIT_IDLE;
        end
        S_WAIT_IDLE: if (acc) begin
          if (bus_rdata == 32'd0) begin
            idx   <= '0;
            state <= S_PARAM;
          end else if (polls == LAST_POLL) begin
            rsp_done    <= 1'b1;
            rsp_timeout <= 1'b1;
            state       <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        S_PARAM: if (cur_zero || acc) begin
          if (idx == 3'd6) state <= S_POST;
          else             idx   <= idx + 1'b1;
        end
        S_POST: if (acc) begin
          polls <= '0;
          state <= S_WAIT_RSP;
        end
        S_WAIT_RSP: if (acc) begin
          rsp_status <= bus_rdata;
          if (bus_rdata[0]) begin
            idx   <= '0;
            state <= (nresp == 2'd0) ? S_CLR_RD : S_DATA;
          end else if (polls == LAST_POLL) begin
            rsp_done    <= 1'b1;
            rsp_timeout <= 1'b1;
            state       <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        S_DATA: if (acc) begin
          rsp_data[{idx[1:0], 5'd0} +: 32] <= bus_rdata;
          if (idx == {1'b0, nresp} - 3'd1) state <= S_CLR_RD;
          else                             idx   <= idx + 1'b1;
        end
        S_CLR_RD: if (acc) begin
          rmw_val <= bus_rdata;
          state   <= S_CLR_WR;
        end
        S_CLR_WR: if (acc) begin
          rsp_done <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

  // R3
  no_zero_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr >= OFF_PRM6 && bus_addr <= OFF_PRM0 |-> bus_wdata != 32'd0);

  // R7
  clear_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == OFF_STS |-> !bus_wdata[0]);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_timeout) |-> rsp_done);

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

endmodule

// File: tb/mbox_requester_tb.sv
module mbox_requester_tb;
  localparam int ADDR_W = 12;
  localparam int MAXP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0]   req_ip_type = '0;
  logic [4:0]   req_inst_id = '0;
  logic [7:0]   req_cmd_type = '0;
  logic [15:0]  req_opcode = '0;
  logic [223:0] req_params = '0;
  logic [1:0]   req_nresp = '0;
  logic bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ready = 1'b0;
  logic [31:0] rsp_status;
  logic [95:0] rsp_data;
  logic rsp_done, rsp_timeout;

  mbox_requester #(.ADDR_W(ADDR_W), .MAX_POLLS(MAXP)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_ip_type, .req_inst_id,
    .req_cmd_type, .req_opcode, .req_params, .req_nresp, .bus_valid,
    .bus_write, .bus_addr, .bus_wdata, .bus_rdata, .bus_ready,
    .rsp_status, .rsp_data, .rsp_done, .rsp_timeout);

  // slave model
  int idle_busy, rsp_wait, wn, n_cmd_rd, n_sts_rd, n_dat_rd, early_wr;
  logic [31:0] sts_val, sts_reg;
  logic [ADDR_W-1:0] wlog_a [16];
  logic [31:0]       wlog_d [16];
  logic lat;

  always @(posedge clk) begin
    bus_ready <= 1'b0;
    if (bus_valid && !bus_ready) begin
      if (!lat) lat <= 1'b1;
      else begin
        lat <= 1'b0;
        bus_ready <= 1'b1;
        if (bus_write) begin
          if (wn < 16) begin wlog_a[wn] <= bus_addr; wlog_d[wn] <= bus_wdata; end
          wn <= wn + 1;
          if (bus_addr == 12'h45C) sts_reg <= bus_wdata;
        end else if (bus_addr == 12'h43C) begin
          n_cmd_rd <= n_cmd_rd + 1;
          if (wn != 0) early_wr <= early_wr + 1;
          if (idle_busy > 0) begin bus_rdata <= 32'hDEAD_0001; idle_busy <= idle_busy - 1; end
          else bus_rdata <= 32'd0;
        end else if (bus_addr == 12'h45C) begin
          n_sts_rd <= n_sts_rd + 1;
          if (rsp_wait > 0) begin bus_rdata <= sts_val & ~32'd1; rsp_wait <= rsp_wait - 1; end
          else bus_rdata <= sts_reg;
        end else begin
          n_dat_rd <= n_dat_rd + 1;
          bus_rdata <= 32'hA5A5_0000 | 32'(bus_addr);
        end
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [6:0]  mask;
    logic [1:0]  nresp;
    logic [31:0] sts;
    logic [7:0]  busy;
    logic [7:0]  wait_n;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{7'h7F, 2'd3, 32'h00AB_0000, 8'd0, 8'd0},
    '{7'h00, 2'd0, 32'h0001_00E0, 8'd2, 8'd3},
    '{7'h55, 2'd1, 32'h1234_001E, 8'd1, 8'd0},
    '{7'h2A, 2'd2, 32'hFFFF_FFFE, 8'd0, 8'd5},
    '{7'h40, 2'd3, 32'h0000_0000, 8'd7, 8'd7}
  };

  function automatic logic [31:0] pval(input int v, input int i);
    return 32'h1000_0000 * (i + 1) + 32'(v * 16 + 1);
  endfunction

  task automatic setup(input int v, input vec_t t);
    req_ip_type  = 3'(v + 1);
    req_inst_id  = 5'(5 * v + 3);
    req_cmd_type = 8'(8'h10 + v);
    req_opcode   = 16'(16'h0100 + v);
    req_nresp    = t.nresp;
    for (int i = 0; i < 7; i++) req_params[32*i +: 32] = t.mask[i] ? pval(v, i) : 32'd0;
    idle_busy = t.busy;
    rsp_wait  = t.wait_n;
    sts_val   = t.sts | 32'd1;
    sts_reg   = t.sts | 32'd1;
    wn = 0; n_cmd_rd = 0; n_sts_rd = 0; n_dat_rd = 0; early_wr = 0;
  endtask

  task automatic launch_and_wait(output bit got);
    int n;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    got = 1'b0;
    while (n < 3000 && !got) begin
      @(negedge clk);
      n++;
      if (rsp_done) got = 1'b1;
    end
    chk(got, "watchdog", {127'd0, got}, 128'd1);
  endtask

  task automatic run_normal(input int v, input vec_t t);
    bit got;
    int ew;
    logic [31:0] cw;
    setup(v, t);
    launch_and_wait(got);
    cw = {req_ip_type, req_inst_id, req_cmd_type, req_opcode};
    // R2
    chk(early_wr == 0 && n_cmd_rd == t.busy + 1, "R2 idle poll", 128'(n_cmd_rd), 128'(t.busy + 1));
    // R3
    ew = 0;
    for (int i = 0; i < 7; i++) if (t.mask[i]) begin
      chk(wlog_a[ew] == 12'h438 - 12'(4 * i) && wlog_d[ew] == pval(v, i), "R3 param write",
          {wlog_a[ew], wlog_d[ew]}, {12'h438 - 12'(4 * i), pval(v, i)});
      ew++;
    end
    // R4
    chk(wlog_a[ew] == 12'h43C && wlog_d[ew] == cw, "R4 command word", {wlog_a[ew], wlog_d[ew]}, {12'h43C, cw});
    // R5
    chk(rsp_status == sts_val, "R5 status", 128'(rsp_status), 128'(sts_val));
    chk(n_sts_rd == t.wait_n + 2, "R5 status polls", 128'(n_sts_rd), 128'(t.wait_n + 2));
    // R6
    chk(n_dat_rd == int'(t.nresp), "R6 data read count", 128'(n_dat_rd), 128'(t.nresp));
    for (int k = 0; k < 3; k++) begin
      logic [31:0] e;
      e = (k < int'(t.nresp)) ? (32'hA5A5_0000 | (32'h458 - 32'(4 * k))) : 32'd0;
      chk(rsp_data[32*k +: 32] == e, "R6 data word", 128'(rsp_data[32*k +: 32]), 128'(e));
    end
    // R7
    chk(wn == ew + 2 && wlog_a[ew+1] == 12'h45C && wlog_d[ew+1] == (sts_val & ~32'd1),
        "R7 clear write", {wlog_a[ew+1], wlog_d[ew+1]}, {12'h45C, sts_val & ~32'd1});
    chk(!rsp_timeout, "R7 no timeout", 128'(rsp_timeout), 128'd0);
    @(negedge clk);
    chk(!rsp_done && req_ready, "R7 single pulse", {126'd0, rsp_done, req_ready}, 128'd1);
  endtask

  initial begin
    bit got;
    lat = 1'b0;
    setup(0, VECS[0]);
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !bus_valid && !rsp_done && !rsp_timeout && rsp_status == 0 && rsp_data == 0,
        "R1 reset state", {124'd0, req_ready, bus_valid, rsp_done, rsp_timeout}, 128'h8);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) run_normal(v, VECS[v]);

    // R8: command register never idles
    setup(1, '{7'h7F, 2'd3, 32'h0000_0100, 8'd200, 8'd0});
    launch_and_wait(got);
    chk(rsp_timeout, "R8 timeout flag", 128'(rsp_timeout), 128'd1);
    chk(wn == 0 && rsp_status == 0, "R8 no writes", 128'(wn), 128'd0);
    chk(n_cmd_rd == MAXP, "R8 poll count", 128'(n_cmd_rd), 128'(MAXP));
    idle_busy = 0;
    @(negedge clk);

    // R9: response never ready
    setup(2, '{7'h03, 2'd3, 32'h0000_00B6, 8'd0, 8'd200});
    launch_and_wait(got);
    chk(rsp_timeout, "R9 timeout flag", 128'(rsp_timeout), 128'd1);
    chk(rsp_status == 32'h0000_00B6, "R9 last status", 128'(rsp_status), 128'h00B6);
    chk(rsp_status[4:1] == 4'hB && rsp_status[7:5] == 3'h5, "R9 error fields",
        {rsp_status[7:5], rsp_status[4:1]}, {3'h5, 4'hB});
    chk(n_dat_rd == 0 && wn == 3, "R9 no data or clear", {n_dat_rd, wn}, {32'd0, 32'd3});
    chk(n_sts_rd == MAXP, "R9 poll count", 128'(n_sts_rd), 128'(MAXP));
    rsp_wait = 0;
    @(negedge clk);

    // R11: request during busy is ignored
    setup(3, VECS[3]);
    req_valid = 1'b1;
    @(negedge clk);
    req_opcode = 16'hBEEF;
    req_params = '0;
    repeat (6) @(negedge clk);
    chk(!req_ready, "R11 busy", 128'(req_ready), 128'd0);
    req_valid = 1'b0;
    begin
      int n = 0;
      got = 1'b0;
      while (n < 3000 && !got) begin @(negedge clk); n++; if (rsp_done) got = 1'b1; end
      chk(got, "watchdog", {127'd0, got}, 128'd1);
    end
    chk(wn == 5 && wlog_d[0] == pval(3, 1) && wlog_d[3][15:0] == 16'h0103, "R11 first request kept",
        {wlog_d[0], wlog_d[3]}, {pval(3, 1), 32'h0103});
    // R10 exercised throughout by two-cycle bus latency
    chk(req_ready, "R10 back to idle", 128'(req_ready), 128'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule